// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a 16-bit processor whose low address bits and data bits leave the chip on one shared set of pins. The core hands it a request (address, direction, write data, a two-bit segment tag and the current interrupt-enable flag). The sequencer then walks a four-state cycle. In the first state the full address is driven and an address latch strobe is pulsed. In the remaining states the shared pins carry data under an active-low read or write strobe. Wait states are added for as long as the memory side holds its ready input low.

The four upper address pins are shared as well. They carry address bits 19..16 in the first state and a status word after it. The status word holds a bus-ownership bit that is driven low, the interrupt-enable flag captured when the cycle began, and the segment tag. A direction output and a data-enable output control external transceivers.

An external DMA master may ask for the bus with a hold input. The request is honoured only between bus cycles. The sequencer then lets go of every bus pin and raises hold-acknowledge. It takes the bus back one clock after hold is withdrawn. Bus pins are modelled as value/enable pairs, so the pad ring performs the actual tri-stating.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle: rd_n_o=1, wr_n_o=1, ale_o=0, den_o=0, hlda_o=0, ad_oe_o=0 and no response is signalled.
- R2: A taken request produces exactly one clock with ale_o=1 (the address state). In that clock ad_o carries address bits 15..0 with ad_oe_o=1, and hi_o carries address bits 19..16 with hi_oe_o=1.
- R3: From the clock after the address state until the cycle ends, hi_o carries the status word {bit3=0 (bus owned), bit2=interrupt-enable flag sampled at request take, bits1..0=segment tag}.
- R4: rd_n_o (read) or wr_n_o (write) is low in every clock from the second state through the last state of the cycle, wait states included. The two strobes are never low together.
- R5: In a write, ad_o carries the write data with ad_oe_o=1 for the whole data phase. In a read, ad_oe_o=0 in the data phase, and the value on ad_i at the ready clock is returned on rsp_rdata_o while rsp_valid_o=1.
- R6: rdy_i is first sampled at the end of the third state, and again at the end of each wait state. Each low sample adds one wait state, so a cycle holds its strobe for 3+N clocks when N samples are low. A high level adds none.
- R7: dir_o is 1 for a write and 0 for a read throughout the cycle. den_o is 1 only in the data phase and never together with ale_o.
- R8: hold_i is granted only between bus cycles. hlda_o rises one clock after hold is seen at a boundary. While hlda_o=1, ctl_oe_o, ad_oe_o and hi_oe_o are all 0 and no request is taken.
- R9: hlda_o falls one clock after hold_i goes low.
- R10: A request already waiting in the last state of a cycle starts its address state in the very next clock, with no idle clock between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core has a bus request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data |
| req_seg_i | input | 2 | Segment tag reported in the status word |
| ie_flag_i | input | 1 | Interrupt-enable flag of the core |
| req_take_o | output | 1 | Request accepted this clock |
| rsp_valid_o | output | 1 | Cycle completes this clock |
| rsp_rdata_o | output | 16 | Read data of the finishing cycle |
| rdy_i | input | 1 | Memory ready; low adds wait states |
| hold_i | input | 1 | DMA master requests the bus |
| hlda_o | output | 1 | Bus handed to the DMA master |
| ad_i | input | 16 | Shared pins, inbound value |
| ad_o | output | 16 | Shared pins, outbound value |
| ad_oe_o | output | 1 | Drive enable of the shared pins |
| hi_o | output | 4 | Upper address / status pins |
| hi_oe_o | output | 1 | Drive enable of the upper pins |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dir_o | output | 1 | Transceiver direction, 1 = outbound |
| den_o | output | 1 | Transceiver enable, active high |
| ctl_oe_o | output | 1 | Drive enable of strobes and transceiver controls |

## Verification
The assertions take it as given that rdy_i and hold_i are stable around each rising edge. They also assume that the memory side eventually raises ready, because a wait state is held for as long as ready stays low. The stimulus changes every input only on the falling edge. The bench models the memory itself: it computes ready from a per-transaction wait count and pulls it high after that many samples. Hold is raised only on falling edges, either in idle time or in the middle of a cycle, and requests are lowered before hold is released, so the take/hold priority at a boundary is never exercised by accident.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;

  localparam int unsigned STAT_FIXED_W = 2;  // owner bit + interrupt-enable bit
endpackage

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid_i,
  input  logic    hold_i,
  input  logic    rdy_i,
  output bus_st_e state_o,
  output logic    take_o
);
  bus_st_e state_q, state_d;
  logic    at_edge;

  assign at_edge = (state_q == ST_IDLE) || (state_q == ST_T4);
  assign take_o  = at_edge && !hold_i && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_T4: begin
        if (hold_i)           state_d = ST_HOLD;
        else if (req_valid_i) state_d = ST_T1;
        else                  state_d = ST_IDLE;
      end
      ST_T1:          state_d = ST_T2;
      ST_T2:          state_d = ST_T3;
      ST_T3, ST_TW:   state_d = rdy_i ? ST_T4 : ST_TW;
      ST_HOLD:        state_d = hold_i ? ST_HOLD : ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_T3 || state_q == ST_TW) && !rdy_i) |=> (state_q == ST_TW)); // R6
  AST_READY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_T3 || state_q == ST_TW) && rdy_i) |=> (state_q == ST_T4)); // R6
  AST_HOLD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T1 || state_q == ST_T2 || state_q == ST_T3 || state_q == ST_TW)
      |=> (state_q != ST_HOLD)); // R8
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !hold_i) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/mux_bus_req.sv
module mux_bus_req
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           state_i,
  input  logic              take_i,
  input  logic              rdy_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              ie_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic cap_rd;

  assign cap_rd = ((state_i == ST_T3) || (state_i == ST_TW)) && rdy_i && !write_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      seg_o   <= '0;
      ie_o    <= 1'b0;
    end else if (take_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      seg_o   <= seg_i;
      ie_o    <= ie_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_o <= '0;
    else if (cap_rd) rdata_o <= ad_i;
  end
endmodule

// File: rtl/mux_bus_drive.sv
module mux_bus_drive
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           state_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_o,
  output logic              hi_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dir_o,
  output logic              den_o,
  output logic              ctl_oe_o,
  output logic              hlda_o,
  output logic              done_o
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic            in_addr, in_data;
  logic [HI_W-1:0] status;

  assign in_addr = (state_i == ST_T1);
  assign in_data = (state_i == ST_T2) || (state_i == ST_T3) ||
                   (state_i == ST_TW) || (state_i == ST_T4);
  assign status  = {1'b0, ie_i, seg_i};

  always_comb begin
    ad_o     = in_addr ? addr_i[DATA_W-1:0] : wdata_i;
    ad_oe_o  = in_addr || (in_data && write_i);
    hi_o     = in_addr ? addr_i[ADDR_W-1:DATA_W] : status;
    hi_oe_o  = in_addr || in_data;
    ale_o    = in_addr;
    rd_n_o   = !(in_data && !write_i);
    wr_n_o   = !(in_data && write_i);
    dir_o    = (in_addr || in_data) ? write_i : 1'b1;
    den_o    = in_data;
    ctl_oe_o = (state_i != ST_HOLD);
    hlda_o   = (state_i == ST_HOLD);
    done_o   = (state_i == ST_T4);
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (!ale_o && den_o)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o)); // R4
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (!rd_n_o || !wr_n_o)); // R4
  AST_DEN_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    den_o |-> !ale_o); // R7
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> (!ctl_oe_o && !ad_oe_o && !hi_oe_o)); // R8
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [ADDR_W-DATA_W-STAT_FIXED_W-1:0] req_seg_i,
  input  logic              ie_flag_i,
  output logic              req_take_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              rdy_i,
  input  logic              hold_i,
  output logic              hlda_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_o,
  output logic              hi_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dir_o,
  output logic              den_o,
  output logic              ctl_oe_o
);
  localparam int unsigned SEG_W = ADDR_W - DATA_W - STAT_FIXED_W;

  logic [1:0]        rst_pipe;
  logic              rst_sn;
  bus_st_e           state;
  logic              take;
  logic              cur_wr, cur_ie;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata, cur_rdata;
  logic [SEG_W-1:0]  cur_seg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  mux_bus_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sn),
    .req_valid_i (req_valid_i),
    .hold_i      (hold_i),
    .rdy_i       (rdy_i),
    .state_o     (state),
    .take_o      (take)
  );

  mux_bus_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_sn),
    .state_i (state),
    .take_i  (take),
    .rdy_i   (rdy_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .seg_i   (req_seg_i),
    .ie_i    (ie_flag_i),
    .ad_i    (ad_i),
    .write_o (cur_wr),
    .addr_o  (cur_addr),
    .wdata_o (cur_wdata),
    .seg_o   (cur_seg),
    .ie_o    (cur_ie),
    .rdata_o (cur_rdata)
  );

  mux_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_sn),
    .state_i  (state),
    .write_i  (cur_wr),
    .addr_i   (cur_addr),
    .wdata_i  (cur_wdata),
    .seg_i    (cur_seg),
    .ie_i     (cur_ie),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .hi_o     (hi_o),
    .hi_oe_o  (hi_oe_o),
    .ale_o    (ale_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .dir_o    (dir_o),
    .den_o    (den_o),
    .ctl_oe_o (ctl_oe_o),
    .hlda_o   (hlda_o),
    .done_o   (rsp_valid_o)
  );

  assign req_take_o  = take;
  assign rsp_rdata_o = cur_rdata;

  AST_TAKE_NOT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    hlda_o |-> !req_take_o); // R8
  AST_B2B_START: assert property (@(posedge clk) disable iff (!rst_sn)
    (rsp_valid_o && req_take_o) |=> ale_o); // R10
endmodule

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        wr;
    logic [19:0] addr;
    logic [15:0] wd;
    logic [1:0]  seg;
    logic        ie;
    int          nw;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, ie_flag, rdy, hold;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, ad_in;
  logic [1:0]  req_seg;
  logic        req_take, rsp_valid, hlda, ad_oe, hi_oe, ale, rd_n, wr_n, dir, den, ctl_oe;
  logic [15:0] rsp_rdata, ad_out;
  logic [3:0]  hi;

  int n_vec = 0;
  int n_bad = 0;
  item_t exp_q[$];
  bit    b2b_expect = 1'b0;
  bit    prev_rsp   = 1'b0;
  bit    done       = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_seg_i(req_seg), .ie_flag_i(ie_flag),
    .req_take_o(req_take), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rdy_i(rdy), .hold_i(hold), .hlda_o(hlda),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .hi_o(hi), .hi_oe_o(hi_oe),
    .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .dir_o(dir), .den_o(den),
    .ctl_oe_o(ctl_oe)
  );

  function automatic logic [15:0] mem_val(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C ^ {12'h000, a[19:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic do_txn(input logic wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] s, input logic ie, input int nw);
    item_t it;
    it.wr = wr; it.addr = a; it.wd = d; it.seg = s; it.ie = ie; it.nw = nw;
    exp_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_seg = s; ie_flag = ie;
    #1;
    while (!req_take) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    ie_flag   = ~ie;  // later changes must not reach the status word
  endtask

  // monitor / scoreboard
  initial begin
    item_t cur;
    bit    active = 1'b0;
    int    k = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      if (rst_n && ale) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected cycle", 32'(ale), 32'h0);
        end else begin
          cur = exp_q.pop_front();
          active = 1'b1; k = 0;
          chk(ad_out == cur.addr[15:0] && ad_oe, "R2 low address", {15'h0, ad_oe, ad_out}, {16'h1, cur.addr[15:0]});
          chk(hi == cur.addr[19:16] && hi_oe, "R2 high address", {27'h0, hi_oe, hi}, {27'h1, cur.addr[19:16]});
          chk(dir == cur.wr && !den, "R7 dir/den in address state", {30'h0, dir, den}, {30'h0, cur.wr, 1'b0});
          if (b2b_expect) begin
            chk(prev_rsp, "R10 back-to-back start", 32'(prev_rsp), 32'h1);
            b2b_expect = 1'b0;
          end
        end
      end else if (active) begin
        k++;
        chk(!ale, "R2 single strobe", 32'(ale), 32'h0);
        if (cur.wr)
          chk(!wr_n && rd_n, "R4 write strobe", {30'h0, rd_n, wr_n}, 32'h2);
        else
          chk(!rd_n && wr_n, "R4 read strobe", {30'h0, rd_n, wr_n}, 32'h1);
        chk(den && dir == cur.wr, "R7 den/dir in data phase", {30'h0, dir, den}, {30'h0, cur.wr, 1'b1});
        chk(hi == {1'b0, cur.ie, cur.seg} && hi_oe, "R3 status word", {27'h0, hi_oe, hi}, {27'h1, 1'b0, cur.ie, cur.seg});
        if (cur.wr)
          chk(ad_oe && ad_out == cur.wd, "R5 write data", {15'h0, ad_oe, ad_out}, {16'h1, cur.wd});
        else
          chk(!ad_oe, "R5 read releases pins", 32'(ad_oe), 32'h0);
        if (rsp_valid) begin
          chk(k == cur.nw + 3, "R6 strobe length", 32'(k), 32'(cur.nw + 3));
          if (!cur.wr)
            chk(rsp_rdata == mem_val(cur.addr), "R5 read data", 32'(rsp_rdata), 32'(mem_val(cur.addr)));
          active = 1'b0;
          rdy = 1'b1;
          ad_in = 16'h0;
        end else begin
          if (k > cur.nw + 3) begin
            chk(1'b0, "R6 cycle overran", 32'(k), 32'(cur.nw + 3));
            active = 1'b0;
          end
          rdy   = (k >= cur.nw + 2);
          ad_in = cur.wr ? 16'h0 : mem_val(cur.addr);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_seg = '0; ie_flag = 1'b0; rdy = 1'b1; hold = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rd_n && wr_n, "R1 strobes idle", {30'h0, rd_n, wr_n}, 32'h3);
    chk(!ale && !den, "R1 ale/den idle", {30'h0, ale, den}, 32'h0);
    chk(!hlda && !ad_oe && !rsp_valid, "R1 no hold/drive/resp", {29'h0, hlda, ad_oe, rsp_valid}, 32'h0);

    // main cycles, various wait counts and patterns
    do_txn(1'b0, 20'h4_0002, 16'h0000, 2'b01, 1'b1, 0);
    repeat (6) @(negedge clk);
    do_txn(1'b1, 20'hA_1235, 16'hBEEF, 2'b10, 1'b0, 0);
    repeat (6) @(negedge clk);
    do_txn(1'b0, 20'hF_FFFF, 16'h0000, 2'b11, 1'b0, 3);
    repeat (9) @(negedge clk);
    do_txn(1'b1, 20'h0_0000, 16'h1234, 2'b00, 1'b1, 5);
    repeat (11) @(negedge clk);

    // R10 back-to-back
    do_txn(1'b0, 20'h3_4005, 16'h0000, 2'b01, 1'b1, 1);
    b2b_expect = 1'b1;
    do_txn(1'b1, 20'h5_AAAA, 16'h5555, 2'b10, 1'b1, 2);
    repeat (10) @(negedge clk);
    chk(!b2b_expect, "R10 second cycle started", 32'(b2b_expect), 32'h0);

    // R8 hold in idle
    hold = 1'b1;
    #1 chk(!hlda, "R8 hlda not yet", 32'(hlda), 32'h0);
    @(negedge clk);
    chk(hlda, "R8 hlda one clock later", 32'(hlda), 32'h1);
    chk(!ctl_oe && !ad_oe && !hi_oe, "R8 pins released", {29'h0, ctl_oe, ad_oe, hi_oe}, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h1_1111;
    for (int i = 0; i < 4; i++) begin
      #1 chk(!req_take && !ale, "R8 request held off", {30'h0, req_take, ale}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    hold = 1'b0;
    #1 chk(hlda, "R9 hlda still up", 32'(hlda), 32'h1);
    @(negedge clk);
    chk(!hlda && ctl_oe, "R9 hlda dropped", {30'h0, hlda, ctl_oe}, 32'h1);
    repeat (2) @(negedge clk);

    // R8 hold raised mid-cycle waits for the boundary
    fork
      do_txn(1'b0, 20'h7_0F0E, 16'h0000, 2'b11, 1'b1, 2);
      begin
        while (!ale) @(negedge clk);
        @(negedge clk);
        hold = 1'b1;
        while (!rsp_valid) begin
          chk(!hlda && ctl_oe, "R8 no grant mid-cycle", {30'h0, hlda, ctl_oe}, 32'h1);
          @(negedge clk);
        end
        @(negedge clk);
        chk(hlda, "R8 grant after cycle end", 32'(hlda), 32'h1);
        hold = 1'b0;
        @(negedge clk);
        chk(!hlda, "R9 release after mid-cycle hold", 32'(hlda), 32'h0);
      end
    join
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all cycles seen", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule